// File: doc/BRIEF.md
# ALU Bypass Select with Load-Use Interlock

This block is the forwarding control of a fully bypassed five-stage pipeline. Each cycle it looks at the two source register indices held in decode and at the instruction now in execute. From them it decides whether each ALU operand should take the execute-stage ALU result instead of the register-file read. It also decides whether decode must hold for one cycle because the producer in execute is a load, whose data does not exist yet.

The execute instruction's write permission is split into two parts. The bypass part is granted only to register-register and register-immediate ALU operations. The stall part is granted to loads. Link-writing jumps return their address through a separate link path by default (`LINK_PATH = 1`), so they neither forward through the ALU bypass nor stall. With `LINK_PATH = 0` they raise the interlock instead. All outputs are combinational functions of the current inputs. The block holds no state, and it has no clock or reset of its own.

Top module: `fwd_ctrl`

## Requirements
- R1: The execute class is a 4-bit code: 0 none, 1 ALU, 2 ALU-immediate, 3 load, 4 store, 5 branch, 6 jump, 7 jump-and-link, 8 jump-register, 9 jump-and-link-register. Codes 10 to 15 write nothing.
- R2: `a_sel` is 1 (execute ALU result) exactly when `dec_rd_en1` is 1, `dec_rs` equals `exe_dst`, `exe_valid` is 1, the class is 1 or 2, `exe_dst` is not 0, and `stall` is 0. Otherwise `a_sel` is 0 (register file).
- R3: `b_sel` follows the rule of R2, using `dec_rt` and `dec_rd_en2`.
- R4: `stall` is 1 exactly when a valid load (class 3) with a non-zero `exe_dst` matches `dec_rs` with `dec_rd_en1` set, or matches `dec_rt` with `dec_rd_en2` set.
- R5: A load in execute never sets `a_sel` or `b_sel`, even when the indices match.
- R6: With `LINK_PATH = 1`, classes 7 and 9 set none of `a_sel`, `b_sel` or `stall`, even for a reader of register 31.
- R7: Whenever `stall` is 1, both `a_sel` and `b_sel` are 0.
- R8: With `exe_valid` at 0 (a bubble in execute), all three outputs are 0.
- R9: An execute destination of register 0 produces neither a bypass nor a stall.
- R10: Classes 0, 4, 5, 6 and 8, and codes 10 to 15, produce neither a bypass nor a stall.
- R11: A cleared read enable stops its operand from matching, even when the index is equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs | input | REG_AW | First source index in decode |
| dec_rt | input | REG_AW | Second source index in decode |
| dec_rd_en1 | input | 1 | Decode instruction reads its first source |
| dec_rd_en2 | input | 1 | Decode instruction reads its second source |
| exe_valid | input | 1 | Execute stage holds a real instruction |
| exe_class | input | 4 | Execute instruction class code (R1) |
| exe_dst | input | REG_AW | Execute destination index |
| a_sel | output | 1 | Operand A source: 1 execute ALU result, 0 register file |
| b_sel | output | 1 | Operand B source: 1 execute ALU result, 0 register file |
| stall | output | 1 | Hold decode for one cycle (load-use) |

## Verification
Two operand decisions can fall in the same cycle. Both selects fire together when `dec_rs`, `dec_rt` and `exe_dst` are equal under an ALU producer. A second-operand load match can raise `stall` while the first operand also matches the same load. The bench provokes both cases directly. It then sweeps every class code against shared and distinct indices, every read-enable pair and both valid values. Each cycle is judged against a behavioural model that requires both selects to fire together when both operands match an ALU producer, and requires `stall` to fire with both selects held at the register file when a load matches.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int CLASS_W = 4;

    typedef enum logic [CLASS_W-1:0] {
        CLS_NONE  = 4'd0,
        CLS_ALU   = 4'd1,
        CLS_ALUI  = 4'd2,
        CLS_LOAD  = 4'd3,
        CLS_STORE = 4'd4,
        CLS_BR    = 4'd5,
        CLS_JMP   = 4'd6,
        CLS_JAL   = 4'd7,
        CLS_JR    = 4'd8,
        CLS_JALR  = 4'd9
    } exe_class_e;

    typedef enum logic {
        SRC_REGFILE = 1'b0,
        SRC_EXE_ALU = 1'b1
    } src_sel_e;

endpackage

// File: rtl/fwd_exe_classify.sv
module fwd_exe_classify
    import fwd_pkg::*;
#(
    parameter int REG_AW    = 5,
    parameter bit LINK_PATH = 1'b1
) (
    input  logic               exe_valid,
    input  logic [CLASS_W-1:0] exe_class,
    input  logic [REG_AW-1:0]  exe_dst,
    output logic               byp_we,
    output logic               stl_we
);

    exe_class_e cls;
    logic       dst_live;

    assign cls      = exe_class_e'(exe_class);
    assign dst_live = exe_valid && (exe_dst != '0);

    // R1: split write permission into a bypass part and an interlock part
    always_comb begin
        byp_we = 1'b0;
        stl_we = 1'b0;
        case (cls)
            CLS_ALU, CLS_ALUI: byp_we = dst_live;
            CLS_LOAD:          stl_we = dst_live;
            CLS_JAL, CLS_JALR: stl_we = dst_live && !LINK_PATH;
            default: begin
                byp_we = 1'b0;
                stl_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fwd_src_match.sv
module fwd_src_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_idx,
    input  logic              src_en,
    input  logic [REG_AW-1:0] exe_dst,
    input  logic              byp_we,
    input  logic              stl_we,
    output logic              byp_hit,
    output logic              stl_hit
);

    logic same;

    assign same    = src_en && (src_idx == exe_dst);
    assign byp_hit = same && byp_we;
    assign stl_hit = same && stl_we;

endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
    import fwd_pkg::*;
#(
    parameter int REG_AW    = 5,
    parameter bit LINK_PATH = 1'b1
) (
    input  logic [REG_AW-1:0]  dec_rs,
    input  logic [REG_AW-1:0]  dec_rt,
    input  logic               dec_rd_en1,
    input  logic               dec_rd_en2,
    input  logic               exe_valid,
    input  logic [CLASS_W-1:0] exe_class,
    input  logic [REG_AW-1:0]  exe_dst,
    output logic               a_sel,
    output logic               b_sel,
    output logic               stall
);

    localparam int NUM_SRC = 2;

    logic                             byp_we;
    logic                             stl_we;
    logic [NUM_SRC-1:0][REG_AW-1:0]   src_idx;
    logic [NUM_SRC-1:0]               src_en;
    logic [NUM_SRC-1:0]               byp_hit;
    logic [NUM_SRC-1:0]               stl_hit;
    src_sel_e [NUM_SRC-1:0]           sel;

    assign src_idx[0] = dec_rs;
    assign src_idx[1] = dec_rt;
    assign src_en[0]  = dec_rd_en1;
    assign src_en[1]  = dec_rd_en2;

    fwd_exe_classify #(
        .REG_AW    (REG_AW),
        .LINK_PATH (LINK_PATH)
    ) u_cls (
        .exe_valid (exe_valid),
        .exe_class (exe_class),
        .exe_dst   (exe_dst),
        .byp_we    (byp_we),
        .stl_we    (stl_we)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        fwd_src_match #(
            .REG_AW (REG_AW)
        ) u_match (
            .src_idx (src_idx[g]),
            .src_en  (src_en[g]),
            .exe_dst (exe_dst),
            .byp_we  (byp_we),
            .stl_we  (stl_we),
            .byp_hit (byp_hit[g]),
            .stl_hit (stl_hit[g])
        );

        // R7: an interlocked cycle keeps every operand on the register file
        assign sel[g] = (byp_hit[g] && !stall) ? SRC_EXE_ALU : SRC_REGFILE;
    end

    assign stall = |stl_hit;
    assign a_sel = (sel[0] == SRC_EXE_ALU);
    assign b_sel = (sel[1] == SRC_EXE_ALU);

endmodule

// File: rtl/fwd_ctrl_chk.sv
module fwd_ctrl_chk
    import fwd_pkg::*;
#(
    parameter int REG_AW    = 5,
    parameter bit LINK_PATH = 1'b1
) (
    input logic [REG_AW-1:0]  dec_rs,
    input logic [REG_AW-1:0]  dec_rt,
    input logic               dec_rd_en1,
    input logic               dec_rd_en2,
    input logic               exe_valid,
    input logic [CLASS_W-1:0] exe_class,
    input logic [REG_AW-1:0]  exe_dst,
    input logic               a_sel,
    input logic               b_sel,
    input logic               stall
);

    always_comb begin
        // R7
        a_r7_stall_holds_rf: assert (!(stall && (a_sel || b_sel)));
        // R8
        a_r8_bubble_quiet: assert (exe_valid || !(a_sel || b_sel || stall));
        // R9
        a_r9_r0_quiet: assert ((exe_dst != '0) || !(a_sel || b_sel || stall));
        // R5
        a_r5_load_no_bypass: assert ((exe_class != 4'd3) || !(a_sel || b_sel));
        // R2
        a_r2_a_needs_match: assert (!a_sel || (dec_rd_en1 && dec_rs == exe_dst));
        // R3
        a_r3_b_needs_match: assert (!b_sel || (dec_rd_en2 && dec_rt == exe_dst));
        // R4
        a_r4_stall_needs_producer: assert (!stall || exe_class == 4'd3 ||
            (!LINK_PATH && (exe_class == 4'd7 || exe_class == 4'd9)));
        // R11
        a_r11_disabled_quiet: assert ((dec_rd_en1 || dec_rd_en2) || !(a_sel || b_sel || stall));
    end

endmodule

bind fwd_ctrl fwd_ctrl_chk #(
    .REG_AW    (REG_AW),
    .LINK_PATH (LINK_PATH)
) u_chk (
    .dec_rs     (dec_rs),
    .dec_rt     (dec_rt),
    .dec_rd_en1 (dec_rd_en1),
    .dec_rd_en2 (dec_rd_en2),
    .exe_valid  (exe_valid),
    .exe_class  (exe_class),
    .exe_dst    (exe_dst),
    .a_sel      (a_sel),
    .b_sel      (b_sel),
    .stall      (stall)
);

// File: tb/fwd_ctrl_tb.sv
module fwd_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] dec_rs = '0;
    logic [AW-1:0] dec_rt = '0;
    logic          dec_rd_en1 = 1'b0;
    logic          dec_rd_en2 = 1'b0;
    logic          exe_valid = 1'b0;
    logic [3:0]    exe_class = '0;
    logic [AW-1:0] exe_dst = '0;
    logic          a_sel;
    logic          b_sel;
    logic          stall;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fwd_ctrl #(.REG_AW(AW), .LINK_PATH(1'b1)) u_dut (
        .dec_rs     (dec_rs),
        .dec_rt     (dec_rt),
        .dec_rd_en1 (dec_rd_en1),
        .dec_rd_en2 (dec_rd_en2),
        .exe_valid  (exe_valid),
        .exe_class  (exe_class),
        .exe_dst    (exe_dst),
        .a_sel      (a_sel),
        .b_sel      (b_sel),
        .stall      (stall)
    );

    // Behavioural reference: which producers may forward and which must hold
    function automatic void model(output bit ea, output bit eb, output bit es);
        int  c  = int'(exe_class);
        bit  ok = exe_valid && (exe_dst != 0);
        bit  ma = dec_rd_en1 && (dec_rs == exe_dst);
        bit  mb = dec_rd_en2 && (dec_rt == exe_dst);
        bit  alu  = ok && (c == 1 || c == 2);
        bit  load = ok && (c == 3);
        es = load && (ma || mb);
        ea = alu && ma && !es;
        eb = alu && mb && !es;
    endfunction

    task automatic expect_bit(string tag, string name, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0b expected=%0b (rs=%0d rt=%0d en=%0b%0b v=%0b cls=%0d dst=%0d)",
                     tag, name, act, exp, dec_rs, dec_rt, dec_rd_en1, dec_rd_en2,
                     exe_valid, exe_class, exe_dst);
        end
    endtask

    // Drive on the rising edge, judge at the falling edge
    task automatic step(string tag, int rs, int rt, bit e1, bit e2, bit v, int cls, int dst);
        bit ea, eb, es;
        @(posedge clk);
        dec_rs = AW'(rs); dec_rt = AW'(rt);
        dec_rd_en1 = e1; dec_rd_en2 = e2;
        exe_valid = v; exe_class = 4'(cls); exe_dst = AW'(dst);
        @(negedge clk);
        model(ea, eb, es);
        expect_bit(tag, "a_sel", a_sel, ea);
        expect_bit(tag, "b_sel", b_sel, eb);
        expect_bit(tag, "stall", stall, es);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        int regs [4] = '{0, 3, 7, 31};
        int dsts [3] = '{0, 3, 31};
        repeat (2) @(posedge clk);
        @(negedge clk);
        // reset state: idle inputs give idle outputs (R8)
        expect_bit("R8", "a_sel", a_sel, 1'b0);
        expect_bit("R8", "b_sel", b_sel, 1'b0);
        expect_bit("R8", "stall", stall, 1'b0);
        rst_n = 1'b1;

        // back-to-back dependent ALU ops
        step("R2", 4, 9, 1, 1, 1, 1, 4);
        expect_bit("R2", "a_sel direct", a_sel, 1'b1);
        step("R3", 9, 4, 1, 1, 1, 2, 4);
        expect_bit("R3", "b_sel direct", b_sel, 1'b1);
        step("R2", 6, 6, 1, 1, 1, 1, 6);
        expect_bit("R3", "both sel", a_sel & b_sel, 1'b1);
        // load-use
        step("R4", 5, 2, 1, 1, 1, 3, 5);
        expect_bit("R4", "stall direct", stall, 1'b1);
        expect_bit("R5", "no load bypass", a_sel, 1'b0);
        step("R7", 8, 8, 1, 1, 1, 3, 8);
        expect_bit("R7", "sel under stall", a_sel | b_sel, 1'b0);
        // link writer followed by reader of r31
        step("R6", 31, 0, 1, 0, 1, 7, 31);
        expect_bit("R6", "jal quiet", a_sel | stall, 1'b0);
        step("R6", 1, 31, 1, 1, 1, 9, 31);
        expect_bit("R6", "jalr quiet", b_sel | stall, 1'b0);
        // writes to r0
        step("R9", 0, 0, 1, 1, 1, 1, 0);
        expect_bit("R9", "r0 alu", a_sel | b_sel | stall, 1'b0);
        step("R9", 0, 0, 1, 1, 1, 3, 0);
        expect_bit("R9", "r0 load", stall, 1'b0);
        // bubble in execute
        step("R8", 4, 4, 1, 1, 0, 3, 4);
        expect_bit("R8", "bubble", a_sel | b_sel | stall, 1'b0);
        // disabled reads
        step("R11", 4, 4, 0, 0, 1, 3, 4);
        expect_bit("R11", "disabled", a_sel | b_sel | stall, 1'b0);
        // non-writing classes
        step("R10", 12, 12, 1, 1, 1, 4, 12);
        expect_bit("R10", "store", a_sel | b_sel | stall, 1'b0);

        // sweep: every class code (R1, R10) against index and enable patterns
        for (int c = 0; c < 16; c++)
            for (int d = 0; d < 3; d++)
                for (int i = 0; i < 4; i++)
                    for (int j = 0; j < 4; j++)
                        for (int e = 0; e < 4; e++)
                            for (int v = 0; v < 2; v++)
                                step("R1", regs[i], regs[j], e[0], e[1], v[0], c, dsts[d]);

        done = 1'b1;
        summary();
    end

endmodule